// File: doc/BRIEF.md
# Prescaled UART Baud Rate Generator

This block turns the system clock into the oversampling strobe of one UART channel. It produces one single-cycle enable pulse for every sixteenth of a serial bit time. The pulse stays in the system clock domain and is never used as a clock. The transmitter uses each pulse to advance its bit shifting, and the receiver uses the same pulse to take its samples. The bit shifting and sampling logic are not part of this block.

The rate comes from two divide stages in series. The first is a prescaler that passes the clock straight through or divides it by four, depending on a control bit. The second is a 16-bit programmable divisor, which accepts any value from 1 to 65535. A divisor of zero stops the output completely.

Software sets up the block through a small byte-wide write port. Any write to a mapped register restarts both counters at once. The first pulse after a write therefore follows the new setting, and no count left over from the old setting delays it.

Top module: `baud_gen`

## Requirements
- R1: While `rst` is high, and after it is released, the divisor is 0, the prescaler passes the clock straight through, and `sample_en` stays low.
- R2: A write to address 1 sets the divisor's upper byte. A write to address 0 sets its lower byte. A write to address 2 sets the prescaler select from bit 0 of the data: 1 divides by four and 0 divides by one.
- R3: With divisor D (1 to 65535) and prescale P (1 or 4), `sample_en` goes high for exactly one cycle in every D*P system cycles.
- R4: While the divisor is 0, `sample_en` never goes high, whatever the prescaler select is.
- R5: With divisor 1 and prescale 1, `sample_en` is high on every cycle.
- R6: A write to address 0, 1 or 2 restarts both counters. `sample_en` is low in the cycle after the write edge, and the first pulse comes exactly D*P cycles after that edge.
- R7: A write to address 3 changes no setting and does not restart the counters. The pulse timing carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register select: 0 divisor low byte, 1 divisor high byte, 2 control, 3 unmapped |
| cfg_wdata | input | 8 | Write data |
| sample_en | output | 1 | Oversampling enable pulse, one cycle wide |

## Verification
The bench sweeps divisors 1 to 16 under both prescale settings. For every setting it checks the whole cycle pattern for two periods after the write, so a design whose counter is off by one, or that counts the prescaler in the wrong phase, shows up as a pulse one cycle early or late. A rewrite in the middle of a long count checks that the counters restart; a design that kept the old count would pulse far too late. A write to the unmapped address in the middle of a period checks that nothing happens, which catches a design that decodes restarts too broadly. A divisor of zero must stay silent under both prescale settings. Divisors 256 and 65535 catch a high byte that is dropped and a compare that wraps.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DATA_W  = 8;
    localparam int DIV_W   = 2 * DATA_W;
    localparam int PRE_DIV = 4;
    localparam int PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV_LO = 2'd0,
        REG_DIV_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0] divisor;
        logic             pre_slow;
    } baud_cfg_t;

    function automatic logic is_mapped(input reg_sel_e sel);
        return sel != REG_NONE;
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output baud_cfg_t             cfg,
    output logic                  reload
);

    reg_sel_e sel;

    assign sel    = reg_sel_e'(addr);
    assign reload = we && is_mapped(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                REG_DIV_LO: cfg.divisor[DATA_W-1:0]     <= wdata;
                REG_DIV_HI: cfg.divisor[DIV_W-1:DATA_W] <= wdata;
                REG_CTRL:   cfg.pre_slow                <= wdata[0];
                default:    ;
            endcase
        end
    end

    // R7: an unmapped write leaves the settings untouched
    assert_unmapped_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_NONE) |=> $stable(cfg))
        else $error("unmapped write changed the configuration");

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int RATIO = PRE_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic enable,
    input  logic slow,
    output logic tick
);

    generate
        if (RATIO > 1) begin : g_div
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

            logic [CW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || reload) begin
                    phase <= '0;
                end else if (enable && slow) begin
                    phase <= (phase == LAST) ? '0 : phase + 1'b1;
                end
            end

            assign tick = enable && (!slow || phase == LAST);

            // R3: in divide mode, prescaler ticks are never back to back
            assert_pre_gap_R3: assert property (@(posedge clk) disable iff (rst)
                (slow && tick && !reload) |=> !tick)
                else $error("prescaler ticked on consecutive cycles");
        end else begin : g_pass
            assign tick = enable;
        end
    endgenerate

endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
#(
    parameter int WIDTH = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [WIDTH-1:0] divisor,
    input  logic             tick,
    output logic             sample_en
);

    logic [WIDTH-1:0] count;
    logic             hit;

    assign hit = tick && (count == divisor - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            count     <= '0;
            sample_en <= 1'b0;
        end else begin
            sample_en <= hit;
            if (tick) begin
                count <= hit ? '0 : count + 1'b1;
            end
        end
    end

    // R3: the count stays below the divisor while the divisor is active
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (divisor != '0) |-> (count < divisor))
        else $error("divider count reached the divisor");

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              sample_en
);

    baud_cfg_t cfg;
    logic      reload;
    logic      active;
    logic      pre_tick;

    baud_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .cfg    (cfg),
        .reload (reload)
    );

    assign active = (cfg.divisor != '0);

    baud_prescaler #(.RATIO(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .enable (active),
        .slow   (cfg.pre_slow),
        .tick   (pre_tick)
    );

    baud_divider #(.WIDTH(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .reload    (reload),
        .divisor   (cfg.divisor),
        .tick      (pre_tick),
        .sample_en (sample_en)
    );

    // R4: a zero divisor keeps the output quiet
    assert_zero_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg.divisor == '0) |-> !sample_en)
        else $error("pulse seen with zero divisor");

    // R6: a restart leaves the output low in the following cycle
    assert_reload_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        reload |=> !sample_en)
        else $error("pulse directly after a configuration write");

    // R5: the fastest setting keeps the output high continuously
    assert_unit_rate_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_en && cfg.divisor == 16'd1 && !cfg.pre_slow && !reload) |=> sample_en)
        else $error("unit rate pulse train broke");

endmodule

// File: tb/test_baud_gen.sv
module test_baud_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       sample_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    baud_gen i_baud_gen (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sample_en (sample_en)
    );

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Leaves the bench at the negedge right after the final (control) write edge.
    task automatic write_cfg(input int div, input bit slow, input string tag);
        wr(2'd1, 8'(div >> 8));
        wr(2'd0, 8'(div));
        wr(2'd2, {7'b0, slow});
        checks++;
        if (sample_en !== 1'b0) begin
            errors++;
            $display("FAIL R6 (%s): sample_en=%0b right after write, expected 0", tag, sample_en);
        end
    endtask

    // Expect a pulse exactly at every multiple of n cycles after the write edge.
    task automatic run_cfg(input int n, input int periods, input int poke_at, input string tag);
        bit bad = 0;
        for (int j = 1; j <= n * periods; j++) begin
            @(negedge clk);
            if (!bad && sample_en !== ((j % n) == 0)) begin
                bad = 1;
                $display("FAIL %s: cycle %0d sample_en=%0b expected %0b",
                         tag, j, sample_en, (j % n) == 0);
            end
            if (j == poke_at) begin
                cfg_we    = 1'b1;
                cfg_addr  = 2'd3;
                cfg_wdata = 8'hFF;
            end else if (j == poke_at + 1) begin
                cfg_we = 1'b0;
            end
        end
        cfg_we = 1'b0;
        checks++;
        if (bad) errors++;
    endtask

    task automatic run_quiet(input int cycles, input string tag);
        bit bad = 0;
        for (int j = 1; j <= cycles; j++) begin
            @(negedge clk);
            if (!bad && sample_en !== 1'b0) begin
                bad = 1;
                $display("FAIL %s: cycle %0d sample_en=%0b expected 0", tag, j, sample_en);
            end
        end
        checks++;
        if (bad) errors++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        cfg_we    = 1'b0;
        cfg_addr  = '0;
        cfg_wdata = '0;
        repeat (4) @(negedge clk);
        checks++;
        if (sample_en !== 1'b0) begin
            errors++;
            $display("FAIL R1: sample_en=%0b in reset, expected 0", sample_en);
        end
        rst = 1'b0;
        run_quiet(40, "R1 after reset");

        // R3: sweep divisors under both prescale settings
        for (int s = 0; s < 2; s++) begin
            for (int d = 1; d <= 16; d++) begin
                write_cfg(d, s[0], "R3 sweep");
                run_cfg(d * (s ? 4 : 1), 2, -5, "R3 sweep");
            end
        end

        // R5: unit rate
        write_cfg(1, 1'b0, "R5");
        run_cfg(1, 24, -5, "R5 every cycle");

        // R2: high byte weight, with and without prescale
        write_cfg(256, 1'b0, "R2");
        run_cfg(256, 2, -5, "R2 high byte");
        write_cfg(257, 1'b1, "R2");
        run_cfg(257 * 4, 2, -5, "R2 both bytes slow");

        // R4: zero divisor silent in both prescale modes
        write_cfg(0, 1'b1, "R4");
        run_quiet(300, "R4 zero slow");
        write_cfg(0, 1'b0, "R4");
        run_quiet(300, "R4 zero fast");

        // R6: restart in the middle of a long count
        write_cfg(200, 1'b0, "R6");
        run_quiet(50, "R6 long count");
        write_cfg(3, 1'b1, "R6 restart");
        run_cfg(12, 3, -5, "R6 restart timing");

        // R7: unmapped write in mid period changes nothing
        write_cfg(10, 1'b0, "R7");
        run_cfg(10, 3, 3, "R7 unmapped write");
        write_cfg(5, 1'b1, "R7");
        run_cfg(20, 2, 7, "R7 unmapped write slow");

        // R3: largest divisor
        write_cfg(65535, 1'b0, "R3 max");
        run_cfg(65535, 1, -5, "R3 max divisor");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule